// File: doc/BRIEF.md
# Command/Response Buffer Control Register Block

This block is the memory-mapped control register window of a trusted-module interface that exchanges commands and responses through a shared data buffer. Software reaches it over a simple little-endian register bus that takes 1, 2, 3 or 4 byte accesses. Through it, software claims and gives up a locality, moves the module between idle and command-ready, launches a command and asks for a running command to be cancelled. Fixed registers describe the interface and the location and size of the data buffer.

Toward the command engine the block issues a one-cycle start pulse with the request length, and a one-cycle cancel pulse. It takes back a completion strobe with an error flag. The request length is the smaller of the size field that the engine's front end has decoded from the command header (supplied on an input) and the configured buffer size. The data buffer itself and the engine are outside the block.

The locality of a write comes from address bits [15:12], so every locality sees the same window at a 4 KiB stride. Only locality 0 can become the active locality, so a start is taken only from locality 0 while a locality is assigned.

Top module: `cmdresp_ctrl_regs`

## Requirements
- R1: After reset, locality-state reads 0x80 (bit 7 register-valid; bit 0 additionally set when `est_flag` is low), control-status reads 0x2 (bit 1 idle, bit 0 fatal clear), locality-status, start and cancel read 0, the identifier word at 0x030 reads 0x0002_5811, the word at 0x034 reads `VENDOR_ID`, the command and response size words (0x058, 0x064) read `BUF_BYTES`, the command and response address words (0x05C, 0x068) read `BUF_BASE`, and the command high-address word (0x060) reads 0.
- R2: A read returns the 32-bit word at the aligned offset `addr[11:2]` shifted right by 8 times `addr[1:0]`; the locality bits [15:12] do not change read data.
- R3: A write to control-request (0x040) with value exactly 0x1 clears the idle bit, exactly 0x2 sets it; any other value leaves control-status unchanged.
- R4: A locality-control (0x008) write of exactly 0x1 sets granted (locality-status bit 0) and assigned (locality-state bit 1) and clears been-seized (locality-status bit 1); exactly 0x2 clears granted and assigned; 0x4, 0x8 and all other values have no effect.
- R5: A start-register (0x04C) write of exactly 0x1 is accepted only while the start bit is clear, a locality is assigned, and the writing locality (`addr[15:12]`) equals the active locality 0; acceptance sets start-register bit 0.
- R6: On an accepted start, `be_start` is high for exactly the one cycle after the write edge and `be_len` then equals min(`hdr_size`, `BUF_BYTES`).
- R7: A cancel-register (0x048) write of exactly 0x1 produces a one-cycle `be_cancel` pulse only while the start bit is set; otherwise it does nothing.
- R8: A `be_done` strobe clears the start bit; if `be_err` is high with it, control-status bit 0 (fatal) sets and stays set until reset.
- R9: Locality-state bit 0 reads as the inverse of `est_flag`.
- R10: The written value is `wdata` masked to the access size (size code n means n+1 low bytes) and compared as a whole; writes at any offset other than a control register's base, and writes to identifier, size and address registers, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address; [15:12] locality, [11:0] window offset |
| bus_size | input | 2 | Access size minus one, in bytes |
| bus_wdata | input | 32 | Write value, right-aligned |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| est_flag | input | 1 | External established flag |
| hdr_size | input | 32 | Size field decoded from the command header |
| be_start | output | 1 | One-cycle command launch pulse |
| be_len | output | LEN_W | Request length in bytes |
| be_cancel | output | 1 | One-cycle cancel pulse |
| be_done | input | 1 | Command completion strobe |
| be_err | input | 1 | Completion reported an error |

## Verification
On every cycle the assertions check that a launch pulse never repeats while a command is pending, that the request length never exceeds the buffer, that a cancel pulse follows only a pending command, that completion always clears the pending bit, that the fatal flag is sticky, and that granted and assigned move together. Whether a particular locality, value or access size is accepted or ignored, the exact reset image of each register, byte-lane read shifts and the length clamp against specific header sizes can only be shown by the bench's sweeps over localities, values, sizes and offsets.

// File: rtl/cr_pkg.sv
package cr_pkg;
   // window offsets (byte addresses inside one 4 KiB locality window)
   localparam logic [11:0] OFF_LOC_STATE = 12'h000;
   localparam logic [11:0] OFF_LOC_CTRL  = 12'h008;
   localparam logic [11:0] OFF_LOC_STS   = 12'h00C;
   localparam logic [11:0] OFF_ID_LO     = 12'h030;
   localparam logic [11:0] OFF_ID_HI     = 12'h034;
   localparam logic [11:0] OFF_CTRL_REQ  = 12'h040;
   localparam logic [11:0] OFF_CTRL_STS  = 12'h044;
   localparam logic [11:0] OFF_CANCEL    = 12'h048;
   localparam logic [11:0] OFF_START     = 12'h04C;
   localparam logic [11:0] OFF_CMD_SIZE  = 12'h058;
   localparam logic [11:0] OFF_CMD_ALO   = 12'h05C;
   localparam logic [11:0] OFF_CMD_AHI   = 12'h060;
   localparam logic [11:0] OFF_RSP_SIZE  = 12'h064;
   localparam logic [11:0] OFF_RSP_ADDR  = 12'h068;

   // command codes
   localparam logic [31:0] CODE_ONE = 32'h1;
   localparam logic [31:0] CODE_TWO = 32'h2;

   // the only locality that can become active
   localparam logic [3:0] ACTIVE_LOC = 4'd0;

   // identifier word fields
   localparam logic [3:0] ID_TYPE    = 4'h1;
   localparam logic [3:0] ID_VER     = 4'h1;
   localparam logic [1:0] ID_XFER    = 2'b11;
   localparam logic       ID_CMDBUF  = 1'b1;
   localparam logic [1:0] ID_SEL     = 2'b01;

   function automatic logic [31:0] size_mask(input logic [1:0] sz);
      logic [31:0] m;
      case (sz)
         2'd0:    m = 32'h0000_00FF;
         2'd1:    m = 32'h0000_FFFF;
         2'd2:    m = 32'h00FF_FFFF;
         default: m = 32'hFFFF_FFFF;
      endcase
      return m;
   endfunction

   function automatic logic [31:0] id_word();
      logic [31:0] w;
      w        = '0;
      w[3:0]   = ID_TYPE;
      w[7:4]   = ID_VER;
      w[12:11] = ID_XFER;
      w[14]    = ID_CMDBUF;
      w[18:17] = ID_SEL;
      return w;
   endfunction
endpackage

// File: rtl/cr_loc_unit.sv
module cr_loc_unit
   import cr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_we,
   input  logic [31:0] ctl_val,
   output logic        assigned,
   output logic        granted,
   output logic        seized
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         assigned <= 1'b0;
         granted  <= 1'b0;
         seized   <= 1'b0;
      end else if (ctl_we) begin
         if (ctl_val == CODE_ONE) begin
            assigned <= 1'b1;
            granted  <= 1'b1;
            seized   <= 1'b0;
         end else if (ctl_val == CODE_TWO) begin
            assigned <= 1'b0;
            granted  <= 1'b0;
         end
      end
   end

   AST_GRANT_FOLLOWS_ASSIGN: assert property (@(posedge clk) disable iff (!rst_n)
      granted == assigned); // R4

   AST_NO_SEIZE: assert property (@(posedge clk) disable iff (!rst_n)
      !seized); // R4
endmodule

// File: rtl/cr_cmd_unit.sv
module cr_cmd_unit
   import cr_pkg::*;
#(
   parameter int BUF_BYTES = 3968,
   parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_we,
   input  logic [31:0]      req_val,
   input  logic             start_we,
   input  logic [31:0]      start_val,
   input  logic [3:0]       wr_loc,
   input  logic             assigned,
   input  logic             cancel_we,
   input  logic [31:0]      cancel_val,
   input  logic [31:0]      hdr_size,
   input  logic             be_done,
   input  logic             be_err,
   output logic             idle,
   output logic             fatal,
   output logic             start_bit,
   output logic             be_start,
   output logic [LEN_W-1:0] be_len,
   output logic             be_cancel
);
   localparam logic [31:0]      BUF_W   = 32'(BUF_BYTES);
   localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_BYTES);

   logic             accept;
   logic             do_cancel;
   logic [LEN_W-1:0] clamp_len;

   always_comb begin
      accept    = start_we && (start_val == CODE_ONE) && !start_bit
                  && assigned && (wr_loc == ACTIVE_LOC);
      do_cancel = cancel_we && (cancel_val == CODE_ONE) && start_bit;
      clamp_len = (hdr_size < BUF_W) ? hdr_size[LEN_W-1:0] : BUF_LEN;
   end

   // idle / command-ready
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle <= 1'b1;
      end else if (req_we) begin
         if (req_val == CODE_ONE)      idle <= 1'b0;
         else if (req_val == CODE_TWO) idle <= 1'b1;
      end
   end

   // start bit, fatal status, backend pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_bit <= 1'b0;
         fatal     <= 1'b0;
         be_start  <= 1'b0;
         be_cancel <= 1'b0;
         be_len    <= '0;
      end else begin
         be_start  <= accept;
         be_cancel <= do_cancel;
         if (accept) begin
            start_bit <= 1'b1;
            be_len    <= clamp_len;
         end else if (be_done) begin
            start_bit <= 1'b0;
         end
         if (be_done && be_err) fatal <= 1'b1;
      end
   end

   AST_START_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      be_start |=> !be_start); // R6

   AST_LEN_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
      be_start |-> (be_len <= BUF_LEN)); // R6

   AST_CANCEL_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      be_cancel |-> $past(start_bit)); // R7

   AST_DONE_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
      be_done |=> !start_bit); // R8

   AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |=> fatal); // R8
endmodule

// File: rtl/cr_read_mux.sv
module cr_read_mux
   import cr_pkg::*;
#(
   parameter logic [31:0] BUF_BASE  = 32'hFED4_0080,
   parameter int          BUF_BYTES = 3968,
   parameter logic [15:0] VENDOR_ID = 16'h1014
) (
   input  logic [11:0] offset,
   input  logic        est_flag,
   input  logic        assigned,
   input  logic        granted,
   input  logic        seized,
   input  logic        idle,
   input  logic        fatal,
   input  logic        start_bit,
   output logic [31:0] rdata
);
   localparam logic [31:0] SIZE_W = 32'(BUF_BYTES);
   localparam logic [31:0] ID_LO  = id_word();

   logic [31:0] word;

   always_comb begin
      word = '0;
      case ({offset[11:2], 2'b00})
         OFF_LOC_STATE: begin
            word[7]   = 1'b1;
            word[4:2] = ACTIVE_LOC[2:0];
            word[1]   = assigned;
            word[0]   = !est_flag;
         end
         OFF_LOC_STS:   word[1:0] = {seized, granted};
         OFF_ID_LO:     word = ID_LO;
         OFF_ID_HI:     word[15:0] = VENDOR_ID;
         OFF_CTRL_STS:  word[1:0] = {idle, fatal};
         OFF_START:     word[0] = start_bit;
         OFF_CMD_SIZE:  word = SIZE_W;
         OFF_CMD_ALO:   word = BUF_BASE;
         OFF_CMD_AHI:   word = '0;
         OFF_RSP_SIZE:  word = SIZE_W;
         OFF_RSP_ADDR:  word = BUF_BASE;
         default:       word = '0;
      endcase
      rdata = word >> {offset[1:0], 3'b000};
   end
endmodule

// File: rtl/cmdresp_ctrl_regs.sv
module cmdresp_ctrl_regs
   import cr_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter logic [31:0] BUF_BASE  = 32'hFED4_0080,
   parameter int          BUF_BYTES = 3968,
   parameter logic [15:0] VENDOR_ID = 16'h1014,
   parameter int          LEN_W     = $clog2(BUF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              est_flag,
   input  logic [31:0]       hdr_size,
   output logic              be_start,
   output logic [LEN_W-1:0]  be_len,
   output logic              be_cancel,
   input  logic              be_done,
   input  logic              be_err
);
   generate
      if (ADDR_W != 16) begin : g_bad_addr
         $error("ADDR_W must be 16: locality sits in bits [15:12]");
      end
      if (BUF_BYTES < 8) begin : g_bad_buf
         $error("BUF_BYTES must hold at least a command header");
      end
      if (LEN_W < $clog2(BUF_BYTES + 1)) begin : g_bad_len
         $error("LEN_W too narrow for BUF_BYTES");
      end
   endgenerate

   logic [11:0] offset;
   logic [3:0]  wr_loc;
   logic [31:0] wval;
   logic        wr;
   logic        assigned, granted, seized;
   logic        idle, fatal, start_bit;

   always_comb begin
      offset = bus_addr[11:0];
      wr_loc = bus_addr[15:12];
      wval   = bus_wdata & size_mask(bus_size);
      wr     = bus_valid && bus_write;
   end

   cr_loc_unit u_loc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (wr && (offset == OFF_LOC_CTRL)),
      .ctl_val  (wval),
      .assigned (assigned),
      .granted  (granted),
      .seized   (seized)
   );

   cr_cmd_unit #(
      .BUF_BYTES (BUF_BYTES),
      .LEN_W     (LEN_W)
   ) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_we     (wr && (offset == OFF_CTRL_REQ)),
      .req_val    (wval),
      .start_we   (wr && (offset == OFF_START)),
      .start_val  (wval),
      .wr_loc     (wr_loc),
      .assigned   (assigned),
      .cancel_we  (wr && (offset == OFF_CANCEL)),
      .cancel_val (wval),
      .hdr_size   (hdr_size),
      .be_done    (be_done),
      .be_err     (be_err),
      .idle       (idle),
      .fatal      (fatal),
      .start_bit  (start_bit),
      .be_start   (be_start),
      .be_len     (be_len),
      .be_cancel  (be_cancel)
   );

   cr_read_mux #(
      .BUF_BASE  (BUF_BASE),
      .BUF_BYTES (BUF_BYTES),
      .VENDOR_ID (VENDOR_ID)
   ) u_rd (
      .offset    (offset),
      .est_flag  (est_flag),
      .assigned  (assigned),
      .granted   (granted),
      .seized    (seized),
      .idle      (idle),
      .fatal     (fatal),
      .start_bit (start_bit),
      .rdata     (bus_rdata)
   );

   AST_START_FROM_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      be_start |-> $past(assigned && wr_loc == ACTIVE_LOC)); // R5
endmodule

// File: tb/cmdresp_ctrl_regs_bench.sv
module cmdresp_ctrl_regs_bench;
   localparam int          TCLK   = 10;
   localparam int          BUFB   = 100;
   localparam logic [31:0] BASE   = 32'h1000_0080;
   localparam logic [15:0] VID    = 16'hA55A;
   localparam int          LW     = $clog2(BUFB + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0, bus_write = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic [1:0]    bus_size = 2'd3;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          est_flag = 1'b1;
   logic [31:0]   hdr_size = '0;
   logic          be_start, be_cancel;
   logic [LW-1:0] be_len;
   logic          be_done = 1'b0, be_err = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   always #(TCLK/2) clk = ~clk;

   cmdresp_ctrl_regs #(
      .BUF_BASE (BASE), .BUF_BYTES (BUFB), .VENDOR_ID (VID)
   ) u_cmdresp_ctrl_regs (
      .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_write (bus_write),
      .bus_addr (bus_addr), .bus_size (bus_size), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .est_flag (est_flag), .hdr_size (hdr_size),
      .be_start (be_start), .be_len (be_len), .be_cancel (be_cancel),
      .be_done (be_done), .be_err (be_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // one-cycle write; returns at the negedge after the write edge
   task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = 2'd3;
      #1 d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic complete(input logic err);
      @(negedge clk);
      be_done = 1'b1; be_err = err;
      @(negedge clk);
      be_done = 1'b0; be_err = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] r, idw, exp;
      idw = 32'h1 | (32'h1 << 4) | (32'h3 << 11) | (32'h1 << 14) | (32'h1 << 17);
      do_reset();

      // R1 reset image
      rd(16'h000, r); check("R1 loc state", r, 32'h80);
      rd(16'h044, r); check("R1 ctrl sts", r, 32'h2);
      rd(16'h00C, r); check("R1 loc sts", r, 32'h0);
      rd(16'h04C, r); check("R1 start", r, 32'h0);
      rd(16'h048, r); check("R1 cancel", r, 32'h0);
      rd(16'h030, r); check("R1 id lo", r, 32'h0002_5811);
      rd(16'h034, r); check("R1 id hi", r, {16'h0, VID});
      rd(16'h058, r); check("R1 cmd size", r, BUFB);
      rd(16'h064, r); check("R1 rsp size", r, BUFB);
      rd(16'h05C, r); check("R1 cmd addr", r, BASE);
      rd(16'h068, r); check("R1 rsp addr", r, BASE);
      rd(16'h060, r); check("R1 cmd addr hi", r, 32'h0);

      // R2 byte-lane shifts, all localities
      for (int loc = 0; loc < 16; loc++) begin
         for (int b = 0; b < 4; b++) begin
            rd({loc[3:0], 12'h030} | 16'(b), r);
            check("R2 id shift", r, idw >> (8*b));
            rd({loc[3:0], 12'h05C} | 16'(b), r);
            check("R2 addr shift", r, BASE >> (8*b));
         end
      end

      // R9 established flag
      est_flag = 1'b0;
      rd(16'h000, r); check("R9 est low", r, 32'h81);
      rd(16'h001, r); check("R9 byte1", r, 32'h0);
      est_flag = 1'b1;
      rd(16'h000, r); check("R9 est high", r, 32'h80);

      // R3 control-request sweep
      for (int v = 0; v < 16; v++) begin
         wr(16'h040, 2'd3, 32'h2);
         wr(16'h040, 2'd3, 32'(v));
         rd(16'h044, r);
         check("R3 from idle", r, (v == 1) ? 32'h0 : 32'h2);
         wr(16'h040, 2'd3, 32'h1);
         wr(16'h040, 2'd3, 32'(v));
         rd(16'h044, r);
         check("R3 from ready", r, (v == 2) ? 32'h2 : 32'h0);
      end
      // R10 masked byte write, oversize value, wrong offset
      wr(16'h040, 2'd0, 32'hFFFF_FF02); rd(16'h044, r); check("R10 byte go idle", r, 32'h2);
      wr(16'h040, 2'd3, 32'h0000_0101); rd(16'h044, r); check("R10 word 0x101 ignored", r, 32'h2);
      wr(16'h041, 2'd0, 32'h1);         rd(16'h044, r); check("R10 off-base ignored", r, 32'h2);
      wr(16'h058, 2'd3, 32'h5);         rd(16'h058, r); check("R10 size ro", r, BUFB);
      wr(16'h030, 2'd3, 32'h0);         rd(16'h030, r); check("R10 id ro", r, idw);

      // R4 locality control sweep of ignored codes
      for (int v = 0; v < 16; v++) begin
         if (v == 1 || v == 2) continue;
         wr(16'h008, 2'd3, 32'(v));
         rd(16'h00C, r); check("R4 ignored sts", r, 32'h0);
         rd(16'h000, r); check("R4 ignored state", r, 32'h80);
      end
      // R5 start refused with no locality assigned
      wr(16'h04C, 2'd3, 32'h1);
      check("R5 no start unassigned", {31'h0, be_start}, 32'h0);
      rd(16'h04C, r); check("R5 start bit clear", r, 32'h0);
      // R7 cancel without pending
      wr(16'h048, 2'd3, 32'h1);
      check("R7 no cancel idle", {31'h0, be_cancel}, 32'h0);

      wr(16'h3008, 2'd3, 32'h1); // request access from locality 3
      rd(16'h00C, r); check("R4 granted", r, 32'h1);
      rd(16'h000, r); check("R4 assigned", r, 32'h82);
      wr(16'h008, 2'd3, 32'h4); rd(16'h000, r); check("R4 seize no effect", r, 32'h82);
      wr(16'h008, 2'd3, 32'h8); rd(16'h00C, r); check("R4 est reset no effect", r, 32'h1);

      // R5 locality sweep: only locality 0 launches
      for (int loc = 1; loc < 16; loc++) begin
         wr({loc[3:0], 12'h04C}, 2'd3, 32'h1);
         check("R5 foreign loc", {31'h0, be_start}, 32'h0);
      end
      rd(16'h04C, r); check("R5 still clear", r, 32'h0);
      wr(16'h04C, 2'd3, 32'h3);
      check("R5 bad value", {31'h0, be_start}, 32'h0);

      // R6 length clamp sweep
      for (int k = 0; k < 6; k++) begin
         case (k)
            0: hdr_size = 32'd0;
            1: hdr_size = 32'd10;
            2: hdr_size = 32'(BUFB - 1);
            3: hdr_size = 32'(BUFB);
            4: hdr_size = 32'(BUFB + 1);
            default: hdr_size = 32'hFFFF_FFFF;
         endcase
         exp = (hdr_size < BUFB) ? hdr_size : BUFB;
         wr(16'h04C, 2'd0, 32'h1);
         check("R6 start pulse", {31'h0, be_start}, 32'h1);
         check("R6 length", 32'(be_len), exp);
         rd(16'h04C, r); check("R5 start set", r, 32'h1);
         @(negedge clk);
         check("R6 pulse one cycle", {31'h0, be_start}, 32'h0);
         // second start while pending refused
         wr(16'h04C, 2'd3, 32'h1);
         check("R5 pending refuse", {31'h0, be_start}, 32'h0);
         // R7 cancel while pending
         wr(16'h048, 2'd3, 32'h1);
         check("R7 cancel pulse", {31'h0, be_cancel}, 32'h1);
         @(negedge clk);
         check("R7 cancel one cycle", {31'h0, be_cancel}, 32'h0);
         complete(1'b0);
         rd(16'h04C, r); check("R8 done clears", r, 32'h0);
         rd(16'h044, r); check("R8 no fatal", r[0], 1'b0);
      end

      // R8 error completion
      wr(16'h04C, 2'd3, 32'h1);
      complete(1'b1);
      rd(16'h044, r); check("R8 fatal set", r, 32'h3);
      rd(16'h04C, r); check("R8 start cleared", r, 32'h0);
      wr(16'h04C, 2'd3, 32'h1);
      complete(1'b0);
      rd(16'h044, r); check("R8 fatal sticky", r, 32'h3);

      // R4 relinquish
      wr(16'h008, 2'd3, 32'h2);
      rd(16'h00C, r); check("R4 relinquish sts", r, 32'h0);
      rd(16'h000, r); check("R4 relinquish state", r, 32'h80);
      wr(16'h04C, 2'd3, 32'h1);
      check("R5 after relinquish", {31'h0, be_start}, 32'h0);

      do_reset();
      rd(16'h044, r); check("R1 fatal cleared by reset", r, 32'h2);

      done_flag = 1;
   end

   initial begin
      for (int i = 0; i < 100000; i++) begin
         @(posedge clk);
         if (done_flag) break;
      end
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog actual 0 expected 1");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule